// File: doc/BRIEF.md
# Path Status Byte Generator

This block produces the path-status (G1) byte that the transmit side places in every outgoing PLCP frame. The byte is made of three fields, each from its own source. A far-end block error (FEBE) nibble carries the BIP-8 error count for the latest frame, as reported by the local receive side. Software can mask this nibble to zero. A remote alarm indication (RAI) bit is either forced high by software or copied from the local receive framing status. Three link bits are written by software and carried through unchanged. Together they form a 24 kbps message channel to the far-end receiver.

Software reaches a single byte-wide control register at one address over a simple register bus. The register has a write strobe and a read strobe, and the read data is combinational. A frame-start strobe samples the error count, the receive framing status and the control register, and builds a new byte. The byte then stays constant until the next strobe. The framer inserts it into the frame.

Top module: `pstat_byte_gen`

## Requirements
- R1: After reset the control register reads 0x00 and the output byte is 0x00.
- R2: A write to address 0x4B stores write-data bits 4..0 as follows: bit 4 is the FEBE mask, bit 3 forces the alarm, and bits 2..0 are the link bits. A read of 0x4B returns those five bits, with bits 7..5 read as 0.
- R3: If the mask bit is 1 when a frame strobe occurs, output bits 7..4 are 0 whatever the error count.
- R4: If the mask bit is 0 when a frame strobe occurs, output bits 7..4 take the error count, limited to a maximum of 8. Any count from 9 to 15 gives 8.
- R5: If the alarm-force bit is 1 when a frame strobe occurs, output bit 3 is 1.
- R6: If the alarm-force bit is 0 when a frame strobe occurs, output bit 3 takes the level of the receive loss-of-frame input.
- R7: Output bits 2..0 take the link bits held in the control register when the frame strobe occurs.
- R8: The output byte changes only on the clock edge that follows a cycle in which the frame strobe is high. Input changes and register writes made between strobes leave it unchanged.
- R9: A write to any other address leaves the control register unchanged, and a read of any other address, or with no read strobe, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| frame_start | input | 1 | One-cycle strobe, once per frame |
| bip_err_cnt | input | 4 | BIP-8 error count of the last received frame |
| rx_lof | input | 1 | Receive loss-of-frame status (1 = out of frame) |
| g1_byte | output | 8 | Path-status byte for the current frame |

## Verification
The assertions assume that frame_start is a single-cycle pulse, sampled on the same edge as the values it qualifies. They also assume that the error count and loss-of-frame inputs hold their values while frame_start is high. The bench always raises the strobe for exactly one cycle. It sets the count and status before the edge that samples them. It covers every count from 0 to 15, including the saturating range 9 to 15. Register writes go both to the control address and to random other addresses. Some writes and input changes are made between strobes to show that the held byte does not change.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int FEBE_W = 4;
  localparam int LINK_W = 3;
  localparam int CTRL_W = 2 + LINK_W;
  localparam int G1_W   = FEBE_W + 1 + LINK_W;
  localparam logic [FEBE_W-1:0] FEBE_MAX = FEBE_W'(8);

  typedef struct packed {
    logic              febe_mask;
    logic              force_rai;
    logic [LINK_W-1:0] link;
  } ctrl_t;

  // limit the error count to the largest legal FEBE value
  function automatic logic [FEBE_W-1:0] febe_sat(input logic [FEBE_W-1:0] cnt);
    return (cnt > FEBE_MAX) ? FEBE_MAX : cnt;
  endfunction

  function automatic logic [FEBE_W-1:0] febe_field(input logic mask,
                                                   input logic [FEBE_W-1:0] cnt);
    return mask ? '0 : febe_sat(cnt);
  endfunction

  function automatic logic rai_field(input logic force_on, input logic lof);
    return force_on | lof;
  endfunction
endpackage

// File: rtl/pstat_ctrl_reg.sv
module pstat_ctrl_reg
  import pstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  logic  addr_hit;
  logic  wr_hit;
  logic  unused_wdata_hi;

  assign addr_hit        = (addr == CTRL_ADDR);
  assign wr_hit          = wr_en && addr_hit;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_comb begin
    rdata = '0;
    if (rd_en && addr_hit) rdata[CTRL_W-1:0] = ctrl_q;
  end

  assign ctrl_o = ctrl_q;

  AST_RD_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CTRL_W] == '0); // R2
  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ctrl_q == $past(wdata[CTRL_W-1:0])); // R2
  AST_WR_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_hit) |=> $stable(ctrl_q)); // R9
  AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr_hit) |-> rdata == '0); // R9
endmodule

// File: rtl/pstat_g1_build.sv
module pstat_g1_build
  import pstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  ctrl_t             ctrl_i,
  input  logic [FEBE_W-1:0] err_cnt,
  input  logic              rx_lof,
  output logic [G1_W-1:0]   g1_o
);
  logic [FEBE_W-1:0] febe_w;
  logic              rai_w;
  logic [G1_W-1:0]   g1_d;
  logic [G1_W-1:0]   g1_q;

  assign febe_w = febe_field(ctrl_i.febe_mask, err_cnt);
  assign rai_w  = rai_field(ctrl_i.force_rai, rx_lof);
  assign g1_d   = {febe_w, rai_w, ctrl_i.link};

  always_ff @(posedge clk) begin
    if (!rst_n)           g1_q <= '0;
    else if (frame_start) g1_q <= g1_d;
  end

  assign g1_o = g1_q;

  AST_FEBE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ctrl_i.febe_mask) |=> g1_q[G1_W-1 -: FEBE_W] == '0); // R3
  AST_FEBE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    g1_q[G1_W-1 -: FEBE_W] <= FEBE_MAX); // R4
  AST_FEBE_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !ctrl_i.febe_mask && err_cnt <= FEBE_MAX)
      |=> g1_q[G1_W-1 -: FEBE_W] == $past(err_cnt)); // R4
  AST_RAI_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && ctrl_i.force_rai) |=> g1_q[LINK_W]); // R5
  AST_RAI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !ctrl_i.force_rai) |=> g1_q[LINK_W] == $past(rx_lof)); // R6
  AST_LINK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> g1_q[LINK_W-1:0] == $past(ctrl_i.link)); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(g1_q)); // R8
endmodule

// File: rtl/pstat_byte_gen.sv
module pstat_byte_gen
  import pstat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_start,
  input  logic [FEBE_W-1:0] bip_err_cnt,
  input  logic              rx_lof,
  output logic [G1_W-1:0]   g1_byte
);
  ctrl_t ctrl_w;

  pstat_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_o(ctrl_w)
  );

  pstat_g1_build u_g1 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctrl_i(ctrl_w),
    .err_cnt(bip_err_cnt), .rx_lof(rx_lof), .g1_o(g1_byte)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (g1_byte == '0 && ctrl_w == '0)); // R1
endmodule

// File: tb/tb_pstat_byte_gen.sv
module tb_pstat_byte_gen;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       frame_start = 0;
  logic [3:0] bip_err_cnt = 0;
  logic       rx_lof = 0;
  logic [7:0] g1_byte;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [4:0] m_ctrl = 0;
  logic [7:0] m_g1 = 0;

  always #4 clk = ~clk;

  pstat_byte_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_start(frame_start), .bip_err_cnt(bip_err_cnt), .rx_lof(rx_lof),
    .g1_byte(g1_byte)
  );

  function automatic logic [7:0] expect_g1(logic [4:0] c, logic [3:0] cnt, logic lof);
    logic [3:0] f;
    if (c[4]) f = 4'd0;
    else if (cnt >= 4'd9) f = 4'd8;
    else f = cnt;
    return {f, (c[3] ? 1'b1 : lof), c[2:0]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 8'h4B) m_ctrl = d[4:0];
  endtask

  task automatic rd_check(string req, logic [7:0] a);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1;
    check(req, reg_rdata, (a == 8'h4B) ? {3'b000, m_ctrl} : 8'h00);
    reg_rd = 0;
  endtask

  task automatic frame(string req, logic [3:0] cnt, logic lof);
    @(negedge clk);
    frame_start = 1; bip_err_cnt = cnt; rx_lof = lof;
    m_g1 = expect_g1(m_ctrl, cnt, lof);
    @(negedge clk);
    frame_start = 0;
    check(req, g1_byte, m_g1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 g1 after reset", g1_byte, 8'h00);
    rd_check("R1 ctrl after reset", 8'h4B);

    // R2: store and read back, upper bits ignored
    wr(8'h4B, 8'hFF);
    rd_check("R2 readback", 8'h4B);
    wr(8'h4B, 8'hA5);
    rd_check("R2 readback hi bits zero", 8'h4B);

    // R9: other addresses
    wr(8'h4A, 8'h1F);
    rd_check("R9 write miss", 8'h4B);
    rd_check("R9 read miss", 8'h4C);
    @(negedge clk);
    reg_addr = 8'h4B; #1;
    check("R9 no read strobe", reg_rdata, 8'h00);

    // R3 mask
    wr(8'h4B, 8'h10);
    frame("R3 mask with count 15", 4'd15, 1'b0);
    frame("R3 mask with count 5", 4'd5, 1'b1);
    // R4 saturation and pass
    wr(8'h4B, 8'h00);
    for (int i = 0; i < 16; i++) frame("R4 count sweep", 4'(i), 1'b0);
    // R5 / R6
    wr(8'h4B, 8'h08);
    frame("R5 forced alarm lof=0", 4'd2, 1'b0);
    wr(8'h4B, 8'h00);
    frame("R6 alarm follows lof=1", 4'd2, 1'b1);
    frame("R6 alarm follows lof=0", 4'd2, 1'b0);
    // R7 link bits
    for (int i = 0; i < 8; i++) begin
      wr(8'h4B, 8'(i));
      frame("R7 link pass", 4'd1, 1'b0);
    end

    // R8 hold between strobes
    wr(8'h4B, 8'h0B);
    frame("R8 base frame", 4'd3, 1'b0);
    @(negedge clk);
    bip_err_cnt = 4'd12; rx_lof = 1;
    wr(8'h4B, 8'h14);
    repeat (3) @(negedge clk);
    check("R8 held after changes", g1_byte, m_g1);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a, d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'h4B;
      d = 8'($urandom);
      if ($urandom % 2 == 0) wr(a, d);
      if ($urandom % 5 == 0) rd_check("R2 R9 random read", 8'($urandom % 2 ? 8'h4B : $urandom));
      frame("R3 R4 R5 R6 R7 random frame", 4'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        bip_err_cnt = 4'($urandom); rx_lof = 1'($urandom);
        @(negedge clk);
        check("R8 random hold", g1_byte, m_g1);
      end
    end
    finish_run();
  end
endmodule